// File: doc/BRIEF.md
# I2C SCL Bit-Timing Divider

This block turns the system clock into the timing enables that an I2C master's bit engine uses to shape SCL. Two programmable dividers run in cascade. A prescaler divides the system clock by (A+1). A second stage counts the prescaler's pulses and divides them by (B+1). Each output of the second stage is one phase step. A fixed sequencer of 22 steps then builds one SCL period from those steps. SCL is low for the first 11 steps and high for the last 11. The sequencer also marks the step where SDA may change and the step where SDA is sampled. The resulting SCL frequency is f_clk / (22 × (A+1) × (B+1)). Software picks A and B so that the bus runs no faster than 400 kHz.

The divider values come from a 16-bit control word. A is in bits 15:14 and B is in bits 13:8. The lower byte belongs to other functions and is ignored here. A new divider value is sampled only at the boundary between SCL periods, so a period is never stretched or cut short by a register write. While the master is idle (`run_i` low), every counter is held at zero and the divider fields are tracked freely. The first period after a START therefore always has full length.

Top module: `i2c_scl_divider`

## Requirements
- R1: While `run_i` is high, `tick_o` pulses for one cycle every N = (A+1)×(B+1) clock cycles. A = `ctrl_i[15:14]` and B = `ctrl_i[13:8]`, both taken from the period in progress.
- R2: `step_o` advances by one on each tick and wraps from 21 to 0. `scl_o` is 0 for steps 0..10 and 1 for steps 11..21, so the SCL period is 22×N cycles with 11×N cycles high. `scl_o` changes only together with a tick or an idle clear.
- R3: After `run_i` rises, the first tick appears after exactly N rising edges with `run_i` high, and `step_o` becomes 1 at that tick.
- R4: `drive_o` pulses together with the tick that moves `step_o` to 5. `sample_o` pulses together with the tick that moves `step_o` to 16. Neither output pulses at any other time.
- R5: `wrap_o` pulses together with the tick that moves `step_o` from 21 to 0, and at no other time.
- R6: A change of `ctrl_i[15:8]` in the middle of a period has no effect on the tick spacing until the wrap tick of that period. Ticks after the wrap use the new value.
- R7: A divider value present in the clock cycle that ends with the wrap tick governs the whole of the next period.
- R8: One edge after `run_i` goes low, `step_o`=0, `scl_o`=0 and no output pulses. No pulse occurs while `run_i` stays low.
- R9: After `rst`, `step_o`=0, `scl_o`=0 and all pulse outputs are 0.
- R10: `ctrl_i[7:0]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Master active; low holds all counters at zero |
| ctrl_i | input | 16 | Control word; [15:14] = A, [13:8] = B |
| step_o | output | 5 | Current phase step, 0..21 |
| scl_o | output | 1 | SCL level to drive (1 = released high) |
| tick_o | output | 1 | One-cycle phase-step pulse |
| drive_o | output | 1 | SDA change point (entry to step 5) |
| sample_o | output | 1 | SDA sample point (entry to step 16) |
| wrap_o | output | 1 | Period boundary (entry to step 0) |

## Verification
The reload of the divider value and the period wrap can fall in the same cycle. The bench provokes this by counting N−1 cycles after the step-21 tick and writing a new divider value in exactly the cycle that ends with the wrap. The design passes if the wrap tick still arrives with the old spacing and every gap in the following period matches the new N. A companion test writes in the middle of a period and expects the old spacing to hold up to the wrap.

// File: rtl/i2c_scl_div_pkg.sv
package i2c_scl_div_pkg;
  localparam int unsigned SCL_STEPS   = 22;
  localparam int unsigned HALF_STEPS  = SCL_STEPS / 2;
  localparam int unsigned DRIVE_STEP  = 5;
  localparam int unsigned SAMPLE_STEP = HALF_STEPS + DRIVE_STEP;
  localparam int unsigned STEP_W      = $clog2(SCL_STEPS);
  localparam int unsigned CTRL_W      = 16;
  localparam int unsigned PRE_LSB     = 14;
  localparam int unsigned PRE_W       = 2;
  localparam int unsigned POST_LSB    = 8;
  localparam int unsigned POST_W      = 6;
endpackage

// File: rtl/i2c_scl_event_div.sv
module i2c_scl_event_div #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  assign hit = en && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim);

  p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_scl_phase_seq.sv
module i2c_scl_phase_seq
  import i2c_scl_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  output logic              last_o,
  output logic [STEP_W-1:0] step_o,
  output logic              scl_o,
  output logic              tick_o,
  output logic              drive_o,
  output logic              sample_o,
  output logic              wrap_o
);
  localparam logic [STEP_W-1:0] LAST_S   = STEP_W'(SCL_STEPS - 1);
  localparam logic [STEP_W-1:0] HALF_S   = STEP_W'(HALF_STEPS);
  localparam logic [STEP_W-1:0] DRIVE_S  = STEP_W'(DRIVE_STEP);
  localparam logic [STEP_W-1:0] SAMPLE_S = STEP_W'(SAMPLE_STEP);

  logic [STEP_W-1:0] step_q, step_nxt;
  logic scl_q, tick_q, drive_q, sample_q, wrap_q;

  assign last_o   = (step_q == LAST_S);
  assign step_nxt = last_o ? '0 : step_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      step_q   <= '0;
      scl_q    <= 1'b0;
      tick_q   <= 1'b0;
      drive_q  <= 1'b0;
      sample_q <= 1'b0;
      wrap_q   <= 1'b0;
    end else begin
      tick_q   <= adv;
      drive_q  <= adv && (step_nxt == DRIVE_S);
      sample_q <= adv && (step_nxt == SAMPLE_S);
      wrap_q   <= adv && last_o;
      if (adv) begin
        step_q <= step_nxt;
        scl_q  <= (step_nxt >= HALF_S);
      end
    end
  end

  assign step_o   = step_q;
  assign scl_o    = scl_q;
  assign tick_o   = tick_q;
  assign drive_o  = drive_q;
  assign sample_o = sample_q;
  assign wrap_o   = wrap_q;

  p_step_range_r2: assert property (@(posedge clk) disable iff (rst)
    step_q <= LAST_S);

  p_scl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(scl_q));

  p_wrap_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> (tick_q && step_q == '0));

  p_drive_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (drive_q || sample_q) |-> (tick_q && (step_q == DRIVE_S || step_q == SAMPLE_S)));
endmodule

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider
  import i2c_scl_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [STEP_W-1:0] step_o,
  output logic              scl_o,
  output logic              tick_o,
  output logic              drive_o,
  output logic              sample_o,
  output logic              wrap_o
);
  logic [PRE_W-1:0]  pre_q;
  logic [POST_W-1:0] post_q;
  logic pre_hit, post_hit, last_step, wrap_now;

  assign wrap_now = post_hit && last_step;

  // divider values are reloaded only while idle or at the period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (!run_i || wrap_now) begin
      pre_q  <= ctrl_i[PRE_LSB +: PRE_W];
      post_q <= ctrl_i[POST_LSB +: POST_W];
    end
  end

  i2c_scl_event_div #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(!run_i), .en(run_i),
    .lim(pre_q), .hit(pre_hit)
  );

  i2c_scl_event_div #(.W(POST_W)) u_post (
    .clk(clk), .rst(rst), .clr(!run_i), .en(pre_hit),
    .lim(post_q), .hit(post_hit)
  );

  i2c_scl_phase_seq u_seq (
    .clk(clk), .rst(rst), .clr(!run_i), .adv(post_hit),
    .last_o(last_step), .step_o(step_o), .scl_o(scl_o),
    .tick_o(tick_o), .drive_o(drive_o), .sample_o(sample_o),
    .wrap_o(wrap_o)
  );

  p_div_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (run_i && !wrap_now) |=> $stable({pre_q, post_q}));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (!tick_o && !scl_o && step_o == '0));
endmodule

// File: tb/i2c_scl_divider_tb.sv
module i2c_scl_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_i = 1'b0;
  logic [15:0] ctrl_i = '0;
  logic [4:0]  step_o;
  logic        scl_o, tick_o, drive_o, sample_o, wrap_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_scl_divider dut_i (
    .clk(clk), .rst(rst), .run_i(run_i), .ctrl_i(ctrl_i),
    .step_o(step_o), .scl_o(scl_o), .tick_o(tick_o),
    .drive_o(drive_o), .sample_o(sample_o), .wrap_o(wrap_o)
  );

  localparam int NV = 6;
  // control word (low byte junk for R10) and expected tick spacing
  localparam logic [15:0] VEC_CTRL [NV] = '{16'h00A5, 16'h443C, 16'h80FF,
                                             16'h0500, 16'hFF01, 16'hC200};
  localparam int VEC_N [NV] = '{1, 10, 3, 6, 256, 12};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int gap);
    gap = 0;
    do begin
      @(posedge clk); #1;
      gap++;
    end while (!tick_o && gap < 2000);
  endtask

  task automatic start(input logic [15:0] c);
    @(negedge clk);
    run_i = 1'b0;
    ctrl_i = c;
    repeat (3) @(negedge clk);
    run_i = 1'b1;
  endtask

  task automatic measure(input int v);
    int n, cyc, ticks, last, first, gap_err, step_err, pulse_err, hi;
    n = VEC_N[v];
    cyc = 0; ticks = 0; last = 0; first = -1;
    gap_err = 0; step_err = 0; pulse_err = 0; hi = 0;
    start(VEC_CTRL[v]);
    while (ticks < 23 && cyc < 30 * n + 100) begin
      @(posedge clk); #1;
      cyc++;
      if (cyc <= 22 * n && scl_o) hi++;
      if (scl_o != (step_o >= 11)) step_err++;
      if (drive_o != (tick_o && step_o == 5)) pulse_err++;
      if (sample_o != (tick_o && step_o == 16)) pulse_err++;
      if (wrap_o != (tick_o && step_o == 0)) pulse_err++;
      if (tick_o) begin
        ticks++;
        if (ticks == 1) first = cyc;
        else if (cyc - last != n) gap_err++;
        if (step_o != 5'(ticks % 22)) step_err++;
        last = cyc;
      end
    end
    chk(first == n, "R3 first tick latency", first, n);
    chk(gap_err == 0 && ticks == 23, "R1/R10 tick spacing errors", gap_err, 0);
    chk(step_err == 0, "R2 step/scl sequence errors", step_err, 0);
    chk(hi == 11 * n, "R2 scl high cycles per period", hi, 11 * n);
    chk(pulse_err == 0, "R4/R5 drive/sample/wrap pulse errors", pulse_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int g, err, cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    chk(step_o == 0 && !scl_o, "R9 reset step/scl", int'(step_o), 0);
    chk(!tick_o && !drive_o && !sample_o && !wrap_o, "R9 reset pulses", int'(tick_o), 0);

    for (int v = 0; v < NV; v++) measure(v);

    // R6: change mid-period, old spacing holds up to the wrap
    start(16'h4000);                       // N=2
    do wait_tick(g); while (step_o != 3);
    @(negedge clk);
    ctrl_i = 16'h0300;                     // N=4
    err = 0;
    do begin
      wait_tick(g);
      if (g != 2) err++;
    end while (step_o != 0);
    chk(err == 0, "R6 old spacing kept until wrap", err, 0);
    wait_tick(g);
    chk(g == 4, "R6 new spacing after wrap", g, 4);

    // R7: write in the cycle that ends with the wrap
    do wait_tick(g); while (step_o != 21);
    repeat (3) @(posedge clk);
    @(negedge clk);
    ctrl_i = 16'h8100;                     // N=6
    wait_tick(g);
    chk(g == 1 && step_o == 0, "R7 wrap tick timing", g, 1);
    err = 0;
    for (int k = 0; k < 22; k++) begin
      wait_tick(g);
      if (g != 6) err++;
    end
    chk(err == 0, "R7 next period uses value written at wrap", err, 0);

    // R8: idle clears everything
    repeat (5) wait_tick(g);
    while (step_o < 11) wait_tick(g);
    @(negedge clk);
    run_i = 1'b0;
    @(posedge clk); #1;
    chk(step_o == 0 && !scl_o && !tick_o, "R8 clear on idle", int'(step_o), 0);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (tick_o || scl_o || drive_o || sample_o || wrap_o || step_o != 0) cnt++;
    end
    chk(cnt == 0, "R8 quiet while idle", cnt, 0);
    start(16'h4200);                       // N=6
    wait_tick(g);
    chk(g == 6 && step_o == 1, "R8 full first step after restart", g, 6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule